// File: doc/BRIEF.md
# Operand Bypass and Hazard Stall Controller

This block steers the operand bypass multiplexers and the freeze logic of a five-stage in-order integer pipeline. Every register source is read in the decode stage and every result is written in the last stage, so only read-after-write dependences can occur. For each of the two ALU operands of the instruction in execute, the block compares the source register number with the destinations held in the two later pipeline latches. It then chooses the newest value, or the register file value when no later latch holds that register.

A load followed at once by a consumer of its result cannot be covered by bypassing. In that case the block holds the program counter and the fetch/decode latch for one cycle and turns the decode/execute latch into an all-zero no-op. After that single bubble, the loaded value is taken from the memory/writeback latch. When the `SHARED_MEM` parameter is set, the design has one memory port for both fetch and data. The block then also freezes fetch and inserts a bubble in every cycle in which a load or store occupies the memory stage. It learns this by registering the memory-operation flags of the instruction in execute.

Top module: `pipe_hazard_unit`

## Requirements
- R1: Each operand select `fwd_a`/`fwd_b` is a 2-bit code with 2'b00 = register file, 2'b10 = execute/memory latch, 2'b01 = memory/writeback latch. The two operands are decided independently, and 2'b11 never appears.
- R2: When the execute/memory latch writes a nonzero register equal to an execute-stage source, that operand's select is 2'b10 in the same cycle, with no stall.
- R3: When only the memory/writeback latch writes a nonzero register equal to an execute-stage source, that operand's select is 2'b01, with no stall.
- R4: When both latches write the same register that a source names, the execute/memory latch wins (select 2'b10).
- R5: Register 0, and any producer whose write enable is low, never causes bypassing or a load-use stall.
- R6: A load in execute that writes a nonzero register named by either decode source raises `stall` and `bubble` in that same cycle. Once the load has moved to the memory stage, no further load-use stall is raised, and the consumer's operand then selects 2'b01.
- R7: With `SHARED_MEM`=0, `stall` and `bubble` are low unless a load-use hazard is present, whatever the non-load producers or stores do.
- R8: With `SHARED_MEM`=1, in the cycle after a load or store was in execute (that is, while it is in the memory stage), `stall` and `bubble` are high.
- R9: While `rst_n` is low and right after it rises, the memory-stage tracking is clear, so with no hazard inputs `stall` and `bubble` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs1 | input | REG_W | First source register of the instruction in decode |
| id_rs2 | input | REG_W | Second source register of the instruction in decode |
| ex_rs1 | input | REG_W | First source register of the instruction in execute |
| ex_rs2 | input | REG_W | Second source register of the instruction in execute |
| ex_rd | input | REG_W | Destination register of the instruction in execute |
| ex_wen | input | 1 | Instruction in execute writes a register |
| ex_is_load | input | 1 | Instruction in execute is a load |
| ex_is_store | input | 1 | Instruction in execute is a store |
| exm_rd | input | REG_W | Destination in the execute/memory latch |
| exm_wen | input | 1 | Write enable in the execute/memory latch |
| mwb_rd | input | REG_W | Destination in the memory/writeback latch |
| mwb_wen | input | 1 | Write enable in the memory/writeback latch |
| fwd_a | output | 2 | Operand A source select |
| fwd_b | output | 2 | Operand B source select |
| stall | output | 1 | Hold the program counter and the fetch/decode latch |
| bubble | output | 1 | Load an all-zero no-op into the decode/execute latch |

## Verification
The bench targets the case where both later latches hold the same register. A design with the priority reversed would feed the ALU a value one instruction too old. It drives register 0 and disabled producers that match a source: a design that skipped these qualifiers would bypass garbage or stall for no reason. The load-use sequence is checked cycle by cycle. A design that stalled twice, or not at all, would show up either as a second stall cycle or as a missing 2'b01 select once the load leaves execute. A shared-port and a split-port instance run side by side, so that a store in the memory stage must freeze fetch only in the shared one.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_MWB = 2'b01,
    SEL_EXM = 2'b10
  } opnd_sel_e;
endpackage

// File: rtl/fwd_pick.sv
module fwd_pick
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] exm_rd,
  input  logic             exm_wen,
  input  logic [REG_W-1:0] mwb_rd,
  input  logic             mwb_wen,
  output opnd_sel_e        sel
);
  logic exm_hit;
  logic mwb_hit;

  always_comb begin
    exm_hit = exm_wen && (exm_rd != '0) && (exm_rd == src);
    mwb_hit = mwb_wen && (mwb_rd != '0) && (mwb_rd == src);
    if (exm_hit)      sel = SEL_EXM;
    else if (mwb_hit) sel = SEL_MWB;
    else              sel = SEL_RF;
  end
endmodule

// File: rtl/load_use_det.sv
module load_use_det #(
  parameter int REG_W = 5,
  parameter int NSRC  = 2
) (
  input  logic [NSRC*REG_W-1:0] id_srcs,
  input  logic [REG_W-1:0]      ex_rd,
  input  logic                  ex_wen,
  input  logic                  ex_is_load,
  output logic                  hazard
);
  logic            producer_ok;
  logic [NSRC-1:0] src_match;

  assign producer_ok = ex_is_load && ex_wen && (ex_rd != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign src_match[g] = (id_srcs[g*REG_W +: REG_W] == ex_rd);
  end

  assign hazard = producer_ok && (|src_match);
endmodule

// File: rtl/port_conflict.sv
module port_conflict #(
  parameter bit SHARED_MEM = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ex_is_load,
  input  logic ex_is_store,
  output logic conflict
);
  if (SHARED_MEM) begin : g_shared
    logic mem_busy_q;
    logic mem_busy_d;
    logic mem_busy_en;

    always_comb begin
      mem_busy_en = 1'b1;
      mem_busy_d  = ex_is_load || ex_is_store;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           mem_busy_q <= 1'b0;
      else if (mem_busy_en) mem_busy_q <= mem_busy_d;
    end

    assign conflict = mem_busy_q;

    // R8: a memory operation leaving execute blocks fetch in the next cycle
    a_r8_port_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_is_load || ex_is_store) |=> conflict);
  end else begin : g_split
    logic unused_ok;
    assign unused_ok = clk ^ rst_n ^ ex_is_load ^ ex_is_store;
    assign conflict  = 1'b0 & unused_ok;
  end
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import hz_pkg::*;
#(
  parameter int REG_W      = 5,
  parameter bit SHARED_MEM = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic [REG_W-1:0] ex_rs1,
  input  logic [REG_W-1:0] ex_rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wen,
  input  logic             ex_is_load,
  input  logic             ex_is_store,
  input  logic [REG_W-1:0] exm_rd,
  input  logic             exm_wen,
  input  logic [REG_W-1:0] mwb_rd,
  input  logic             mwb_wen,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             stall,
  output logic             bubble
);
  localparam int NSRC = 2;

  logic [NSRC*REG_W-1:0] id_srcs;
  logic [NSRC*REG_W-1:0] ex_srcs;
  opnd_sel_e             sel [NSRC];
  logic                  lu_hazard;
  logic                  port_busy;
  logic                  hold;

  assign id_srcs = {id_rs2, id_rs1};
  assign ex_srcs = {ex_rs2, ex_rs1};

  for (genvar g = 0; g < NSRC; g++) begin : g_opnd
    fwd_pick #(.REG_W(REG_W)) u_pick (
      .src     (ex_srcs[g*REG_W +: REG_W]),
      .exm_rd  (exm_rd),
      .exm_wen (exm_wen),
      .mwb_rd  (mwb_rd),
      .mwb_wen (mwb_wen),
      .sel     (sel[g])
    );
  end

  load_use_det #(.REG_W(REG_W), .NSRC(NSRC)) u_lu (
    .id_srcs    (id_srcs),
    .ex_rd      (ex_rd),
    .ex_wen     (ex_wen),
    .ex_is_load (ex_is_load),
    .hazard     (lu_hazard)
  );

  port_conflict #(.SHARED_MEM(SHARED_MEM)) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .ex_is_load  (ex_is_load),
    .ex_is_store (ex_is_store),
    .conflict    (port_busy)
  );

  assign hold   = lu_hazard || port_busy;
  assign fwd_a  = sel[0];
  assign fwd_b  = sel[1];
  assign stall  = hold;
  assign bubble = hold;

  // R1: reserved code never reaches the muxes
  a_r1_legal_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'b11) && (fwd_b != 2'b11));

  // R4: newest producer wins for operand A
  a_r4_exm_first: assert property (@(posedge clk) disable iff (!rst_n)
    (exm_wen && mwb_wen && exm_rd == ex_rs1 && mwb_rd == ex_rs1 && ex_rs1 != '0)
      |-> (fwd_a == 2'b10));

  // R5: register 0 is never bypassed
  a_r5_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
    ((ex_rs1 == '0) |-> (fwd_a == 2'b00)) and ((ex_rs2 == '0) |-> (fwd_b == 2'b00)));

  // R6: dependent load in execute freezes front end and drops a bubble
  a_r6_load_use: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_is_load && ex_wen && ex_rd != '0 && (ex_rd == id_rs1 || ex_rd == id_rs2))
      |-> (stall && bubble));

  if (!SHARED_MEM) begin : g_chk_split
    // R7: without a shared port only a load in execute can freeze fetch
    a_r7_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (ex_is_load && ex_wen));
  end
endmodule

// File: tb/pipe_hazard_unit_bench.sv
module pipe_hazard_unit_bench;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [RW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, exm_rd, mwb_rd;
  logic          ex_wen, ex_is_load, ex_is_store, exm_wen, mwb_wen;
  logic [1:0]    fwd_a, fwd_b, fwd_a_s, fwd_b_s;
  logic          stall, bubble, stall_s, bubble_s;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pipe_hazard_unit #(.REG_W(RW), .SHARED_MEM(1'b0)) u_pipe_hazard_unit (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_wen(ex_wen),
    .ex_is_load(ex_is_load), .ex_is_store(ex_is_store),
    .exm_rd(exm_rd), .exm_wen(exm_wen), .mwb_rd(mwb_rd), .mwb_wen(mwb_wen),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .bubble(bubble));

  pipe_hazard_unit #(.REG_W(RW), .SHARED_MEM(1'b1)) u_pipe_hazard_unit_shmem (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_wen(ex_wen),
    .ex_is_load(ex_is_load), .ex_is_store(ex_is_store),
    .exm_rd(exm_rd), .exm_wen(exm_wen), .mwb_rd(mwb_rd), .mwb_wen(mwb_wen),
    .fwd_a(fwd_a_s), .fwd_b(fwd_b_s), .stall(stall_s), .bubble(bubble_s));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    id_rs1 = '0; id_rs2 = '0; ex_rs1 = '0; ex_rs2 = '0; ex_rd = '0;
    ex_wen = 1'b0; ex_is_load = 1'b0; ex_is_store = 1'b0;
    exm_rd = '0; exm_wen = 1'b0; mwb_rd = '0; mwb_wen = 1'b0;
  endtask

  // drive at falling edge, sample 1 ns later, before the next rising edge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle();
    ex_is_store = 1'b1;
    repeat (3) step();
    ex_is_store = 1'b0;
    #1;
    chk("R9 shared stall in reset", stall_s, 0);
    chk("R9 split stall in reset", stall, 0);
    step();
    rst_n = 1'b1;
    step(); #1;
    chk("R9 shared stall after reset", stall_s, 0);
    chk("R9 bubble after reset", bubble_s, 0);
    chk("R1 select after reset", fwd_a, 0);
  endtask

  task automatic t_exm_fwd();
    step(); idle();
    ex_rs1 = 5'd7; ex_rs2 = 5'd9; exm_rd = 5'd7; exm_wen = 1'b1; #1;
    chk("R2 operand A from EX/MEM", fwd_a, 2);
    chk("R1 operand B independent", fwd_b, 0);
    chk("R2 no stall", stall, 0);
  endtask

  task automatic t_mwb_fwd();
    step(); idle();
    ex_rs1 = 5'd4; ex_rs2 = 5'd12; mwb_rd = 5'd12; mwb_wen = 1'b1;
    exm_rd = 5'd13; exm_wen = 1'b1; #1;
    chk("R3 operand B from MEM/WB", fwd_b, 1);
    chk("R3 operand A untouched", fwd_a, 0);
    chk("R3 no stall", stall, 0);
  endtask

  task automatic t_priority();
    step(); idle();
    ex_rs1 = 5'd21; ex_rs2 = 5'd21; exm_rd = 5'd21; exm_wen = 1'b1;
    mwb_rd = 5'd21; mwb_wen = 1'b1; #1;
    chk("R4 operand A EX/MEM wins", fwd_a, 2);
    chk("R4 operand B EX/MEM wins", fwd_b, 2);
    step();
    exm_wen = 1'b0; #1;
    chk("R5 disabled EX/MEM falls to MEM/WB", fwd_a, 1);
  endtask

  task automatic t_zero_wen();
    step(); idle();
    ex_rs1 = 5'd0; ex_rs2 = 5'd0; exm_wen = 1'b1; mwb_wen = 1'b1; #1;
    chk("R5 reg0 operand A", fwd_a, 0);
    chk("R5 reg0 operand B", fwd_b, 0);
    step(); idle();
    ex_rs1 = 5'd6; exm_rd = 5'd6; mwb_rd = 5'd6; #1;
    chk("R5 write enables off", fwd_a, 0);
    step(); idle();
    ex_is_load = 1'b1; ex_wen = 1'b1; ex_rd = 5'd0; #1;
    chk("R5 load to reg0 no stall", stall, 0);
    step(); idle();
    ex_is_load = 1'b1; ex_wen = 1'b0; ex_rd = 5'd8; id_rs1 = 5'd8; #1;
    chk("R5 load with wen off no stall", stall, 0);
  endtask

  task automatic t_load_use();
    step(); idle();
    ex_is_load = 1'b1; ex_wen = 1'b1; ex_rd = 5'd3; id_rs2 = 5'd3; id_rs1 = 5'd1; #1;
    chk("R6 load-use stall", stall, 1);
    chk("R6 load-use bubble", bubble, 1);
    // load moves to memory stage, bubble in execute, decode held
    step(); idle();
    id_rs2 = 5'd3; id_rs1 = 5'd1; exm_rd = 5'd3; exm_wen = 1'b1; #1;
    chk("R6 single bubble only", stall, 0);
    chk("R8 shared port busy with load in memory", stall_s, 1);
    step(); idle();
    ex_rs2 = 5'd3; ex_rs1 = 5'd1; mwb_rd = 5'd3; mwb_wen = 1'b1; #1;
    chk("R6 consumer takes MEM/WB", fwd_b, 1);
    chk("R6 shared port free again", stall_s, 0);
  endtask

  task automatic t_alu_no_stall();
    step(); idle();
    ex_wen = 1'b1; ex_rd = 5'd10; id_rs1 = 5'd10; id_rs2 = 5'd10; #1;
    chk("R7 ALU producer no stall", stall, 0);
  endtask

  task automatic t_struct();
    step(); idle();
    ex_is_store = 1'b1; ex_rs1 = 5'd2; #1;
    chk("R8 no stall while store in execute", stall_s, 0);
    step(); idle(); #1;
    chk("R8 shared port stall", stall_s, 1);
    chk("R8 shared port bubble", bubble_s, 1);
    chk("R7 split port no stall after store", stall, 0);
    step(); #1;
    chk("R8 stall clears", stall_s, 0);
  endtask

  initial begin
    t_reset();
    t_exm_fwd();
    t_mwb_fwd();
    t_priority();
    t_zero_wen();
    t_load_use();
    t_alu_no_stall();
    t_struct();
    step();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule